// File: doc/BRIEF.md
# Dual-Rail Receiver with Completion Detection

This block accepts a word in which every bit travels on its own pair of wires, a true rail and a false rail. A bit carries no data while both rails are low. It carries a value once exactly one rail is high. Because the code itself shows when a bit is present, the sender needs no strobe. Bits may arrive in any order and at different times. The receiver decides that a word is complete when every pair holds a valid code. It decides that the word has been withdrawn once every pair has returned to the empty state.

Each pair feeds a small state-holding slot. The slots feed a balanced tree of two-input Muller C-element nodes. Every node is modelled as a clocked state holder: its output rises when both inputs are high, falls when both are low, and otherwise repeats its stored value. The root of the tree is registered as the done flag. When the word completes, the decoded word is captured and then held until the next complete word. A pair with both rails high is illegal and sets a sticky error flag. A phase machine follows the handshake through four named states:
- SPACER: no bit present.
- ARRIVE: some bits present, word incomplete.
- COMPLETE: done, all bits present.
- RETURN: done, some bits withdrawn.

Its transitions are:
- SPACER→ARRIVE on the first bit present.
- SPACER or ARRIVE→COMPLETE on the tree root rising.
- ARRIVE→SPACER when every bit is withdrawn before completion.
- COMPLETE→RETURN on the first bit withdrawn.
- COMPLETE or RETURN→SPACER on the tree root falling.

Top module: `dr_receiver`

## Requirements
- R1: Pair i is written {rail_t[i], rail_f[i]}. The code 2'b00 is the spacer, 2'b01 is logic 0 and 2'b10 is logic 1. Bit i of data_o takes the decoded value.
- R2: done_o becomes 1 after the first rising clock edge at which every pair holds 2'b01 or 2'b10, and not earlier.
- R3: done_o stays 0 while any pair is still the spacer, whatever order the other pairs arrive in.
- R4: Once high, done_o stays 1 while at least one pair still holds a code. It becomes 0 after the first edge at which every pair is 2'b00.
- R5: data_o loads the decoded word at the edge where the word completes. It holds that value while pairs return to the spacer and while the inputs are idle.
- R6: A pair at 2'b11 sampled at an edge sets err_o after that edge. err_o then stays 1 until reset.
- R7: A pair at 2'b11 keeps the presence state of its slot. It cannot complete a word that was incomplete, and it cannot release a word that is done.
- R8: While rst_n is low (asynchronous, active low), done_o, data_o, err_o, every slot state and every tree node are 0, and the phase is SPACER.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_t | input | WIDTH | True rail of each bit pair |
| rail_f | input | WIDTH | False rail of each bit pair |
| data_o | output | WIDTH | Decoded word, held between completions |
| done_o | output | 1 | Completion flag from the C-element tree |
| err_o | output | 1 | Sticky illegal-code flag |

## Verification
Each result is due one rising edge after the rails change: done_o, data_o and err_o are all registered directly from the sampled pairs and the tree. The bench changes the rails on a falling edge and samples the outputs on the next falling edge. It first checks at the falling edge where it drives, to show that nothing has moved early, and then checks again one full cycle later. During staggered arrival and partial return, the bench checks every intermediate step at that one-cycle distance. This shows that done_o and data_o neither move early nor move late.

// File: rtl/dr_pkg.sv
package dr_pkg;

    // Pair code seen as {true_rail, false_rail}.
    typedef enum logic [1:0] {
        PAIR_EMPTY = 2'b00,
        PAIR_ZERO  = 2'b01,
        PAIR_ONE   = 2'b10,
        PAIR_BAD   = 2'b11
    } pair_e;

    // Handshake phase tracked by the receiver.
    typedef enum logic [1:0] {
        PH_SPACER   = 2'b00,
        PH_ARRIVE   = 2'b01,
        PH_COMPLETE = 2'b10,
        PH_RETURN   = 2'b11
    } phase_e;

endpackage

// File: rtl/dr_celement.sv
// Clocked model of a two-input Muller C-element.
// The output follows the agreed input value at once; the stored state
// supplies the output while the inputs disagree.
module dr_celement (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic out_y
);
    logic state_q;

    assign out_y = (in_a & in_b) | (state_q & (in_a | in_b));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= 1'b0;
        end else begin
            state_q <= out_y;
        end
    end
endmodule

// File: rtl/dr_rail_slot.sv
// One bit pair: classifies the code and holds presence across an illegal code.
module dr_rail_slot
    import dr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_t,
    input  logic rail_f,
    output logic held,
    output logic valid,
    output logic illegal,
    output logic value
);
    pair_e code;
    logic  held_q;

    assign code = pair_e'({rail_t, rail_f});

    always_comb begin
        valid   = 1'b0;
        illegal = 1'b0;
        value   = 1'b0;
        held    = held_q;
        unique case (code)
            PAIR_EMPTY: begin
                held = 1'b0;
            end
            PAIR_ZERO: begin
                valid = 1'b1;
                held  = 1'b1;
            end
            PAIR_ONE: begin
                valid = 1'b1;
                value = 1'b1;
                held  = 1'b1;
            end
            PAIR_BAD: begin
                illegal = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= held;
        end
    end
endmodule

// File: rtl/dr_ctree.sv
// Balanced C-element tree over WIDTH leaves; padding leaves mirror leaf 0
// so they never change the agreement condition.
module dr_ctree #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] leaf,
    output logic             root
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int SPAN   = 1 << LEVELS;
    localparam int NODES  = 2 * SPAN - 1;

    logic node [1:NODES];

    for (genvar g = 0; g < SPAN; g++) begin : g_leaf
        if (g < WIDTH) begin : g_real
            assign node[SPAN + g] = leaf[g];
        end else begin : g_pad
            assign node[SPAN + g] = leaf[0];
        end
    end

    for (genvar n = 1; n < SPAN; n++) begin : g_join
        dr_celement u_cel (
            .clk   (clk),
            .rst_n (rst_n),
            .in_a  (node[2 * n]),
            .in_b  (node[2 * n + 1]),
            .out_y (node[n])
        );
    end

    assign root = node[1];
endmodule

// File: rtl/dr_receiver.sv
// Dual-rail receiver: slots, completion tree, phase machine, output registers.
module dr_receiver
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic [WIDTH-1:0] data_o,
    output logic             done_o,
    output logic             err_o
);
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] valid;
    logic [WIDTH-1:0] illegal;
    logic [WIDTH-1:0] value;
    logic             root;
    logic             any_held;
    logic             all_held;
    logic             all_valid;
    logic             any_illegal;
    logic             load_word;

    phase_e phase_q;
    phase_e phase_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        dr_rail_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .rail_t  (rail_t[i]),
            .rail_f  (rail_f[i]),
            .held    (held[i]),
            .valid   (valid[i]),
            .illegal (illegal[i]),
            .value   (value[i])
        );
    end

    dr_ctree #(.WIDTH(WIDTH)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .leaf  (held),
        .root  (root)
    );

    assign any_held    = |held;
    assign all_held    = &held;
    assign all_valid   = &valid;
    assign any_illegal = |illegal;
    assign load_word   = root & all_valid;

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_SPACER;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Phase transitions
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_SPACER: begin
                if (root) begin
                    phase_d = PH_COMPLETE;
                end else if (any_held) begin
                    phase_d = PH_ARRIVE;
                end
            end
            PH_ARRIVE: begin
                if (root) begin
                    phase_d = PH_COMPLETE;
                end else if (!any_held) begin
                    phase_d = PH_SPACER;
                end
            end
            PH_COMPLETE: begin
                if (!root) begin
                    phase_d = PH_SPACER;
                end else if (!all_held) begin
                    phase_d = PH_RETURN;
                end
            end
            PH_RETURN: begin
                if (!root) begin
                    phase_d = PH_SPACER;
                end
            end
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            data_o <= '0;
            err_o  <= 1'b0;
        end else begin
            done_o <= root;
            if (load_word) begin
                data_o <= value;
            end
            if (any_illegal) begin
                err_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dr_receiver_chk.sv
module dr_receiver_chk
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] rail_t,
    input logic [WIDTH-1:0] rail_f,
    input logic [WIDTH-1:0] data_o,
    input logic             done_o,
    input logic             err_o,
    input phase_e           phase
);
    logic all_code;
    logic all_empty;
    logic some_bad;

    assign all_code  = &(rail_t ^ rail_f);
    assign all_empty = ~|(rail_t | rail_f);
    assign some_bad  = |(rail_t & rail_f);

    assert_done_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(all_code));

    assert_done_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(all_empty));

    assert_done_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o == (phase == PH_COMPLETE || phase == PH_RETURN));

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_o));

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        some_bad |=> err_o);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

bind dr_receiver dr_receiver_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rail_t (rail_t),
    .rail_f (rail_f),
    .data_o (data_o),
    .done_o (done_o),
    .err_o  (err_o),
    .phase  (phase_q)
);

// File: tb/tb_dr_receiver.sv
// Companion encoder: bad bits give 11, present bits give their code, others 00.
module dr_encoder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word,
    input  logic [WIDTH-1:0] present,
    input  logic [WIDTH-1:0] bad,
    output logic [WIDTH-1:0] rail_t,
    output logic [WIDTH-1:0] rail_f
);
    assign rail_t = bad | (present & word);
    assign rail_f = bad | (present & ~word);
endmodule

module tb_dr_receiver;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word = '0;
    logic [W-1:0] present = '0;
    logic [W-1:0] bad = '0;
    logic [W-1:0] rail_t;
    logic [W-1:0] rail_f;
    logic [W-1:0] data_o;
    logic         done_o;
    logic         err_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dr_encoder #(.WIDTH(W)) u_enc (
        .word(word), .present(present), .bad(bad),
        .rail_t(rail_t), .rail_f(rail_f)
    );

    dr_receiver #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .rail_t(rail_t), .rail_f(rail_f),
        .data_o(data_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [W-1:0] w, input logic [W-1:0] p, input logic [W-1:0] b);
        word = w;
        present = p;
        bad = b;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive('0, '0, '0);
        step();
        check("R8 done in reset", 32'(done_o), 32'd0);
        check("R8 data in reset", 32'(data_o), 32'd0);
        check("R8 err in reset", 32'(err_o), 32'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_full_word(input logic [W-1:0] w);
        drive(w, '1, '0);
        check("R2 done not early", 32'(done_o), 32'd0);
        step();
        check("R2 done after complete", 32'(done_o), 32'd1);
        check("R1 R5 decoded word", 32'(data_o), 32'(w));
        drive(w, '0, '0);
        step();
        check("R4 done released", 32'(done_o), 32'd0);
        check("R5 data held in spacer", 32'(data_o), 32'(w));
    endtask

    task automatic t_partial_return();
        drive(8'hA5, '1, '0);
        step();
        check("R1 R5 word A5", 32'(data_o), 32'hA5);
        drive(8'h5A, 8'h0F, '0);
        step();
        check("R4 done held on partial return", 32'(done_o), 32'd1);
        check("R5 data held on partial return", 32'(data_o), 32'hA5);
        drive(8'h5A, 8'h01, '0);
        step();
        check("R4 done held one bit left", 32'(done_o), 32'd1);
        drive('0, '0, '0);
        step();
        check("R4 done low when all spacer", 32'(done_o), 32'd0);
        check("R5 data held after return", 32'(data_o), 32'hA5);
    endtask

    task automatic t_stagger();
        logic [W-1:0] p;
        p = '0;
        for (int i = W - 1; i >= 0; i--) begin
            p[i] = 1'b1;
            drive(8'h3C, p, '0);
            step();
            if (i != 0) begin
                check("R3 done low during arrival", 32'(done_o), 32'd0);
                check("R5 data held during arrival", 32'(data_o), 32'hA5);
            end
        end
        check("R2 done after last arrival", 32'(done_o), 32'd1);
        check("R1 word 3C", 32'(data_o), 32'h3C);
        drive('0, '0, '0);
        step();
        check("R4 released after stagger", 32'(done_o), 32'd0);
    endtask

    task automatic t_illegal();
        drive(8'hC3, 8'hFB, 8'h04);
        step();
        check("R7 bad pair cannot complete", 32'(done_o), 32'd0);
        check("R6 err set", 32'(err_o), 32'd1);
        drive(8'hC3, 8'hFF, '0);
        step();
        check("R2 completes once repaired", 32'(done_o), 32'd1);
        check("R1 word C3", 32'(data_o), 32'hC3);
        drive('0, '0, 8'h20);
        step();
        check("R7 bad pair cannot release", 32'(done_o), 32'd1);
        drive('0, '0, '0);
        step();
        check("R4 release after bad cleared", 32'(done_o), 32'd0);
        check("R6 err sticky", 32'(err_o), 32'd1);
        step();
        check("R6 err still sticky", 32'(err_o), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_full_word(8'hA5);
        t_partial_return();
        t_stagger();
        t_full_word(8'h00);
        t_full_word(8'hFF);
        t_illegal();
        t_reset();
        t_full_word(8'h69);
        check("R8 err clear after reset", 32'(err_o), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule